// File: doc/BRIEF.md
# Subvector Lane Rearrangement Engine

The engine copies a vector of short subvectors from one region of a byte-addressed register store into another, changing the lane layout of every subvector on the way. The operation covers `vl` subvectors. A source subvector is `src_len` elements wide and a destination subvector is `dst_len` elements wide. Every destination lane names the source lane it copies through a constant selector that arrives with the operation. Source and destination lengths are set separately, so the same engine can permute lanes, duplicate a lane, or pull a single lane out of each subvector into a dense scalar vector.

A one-cycle `start` pulse hands over the whole configuration, which is latched. The engine then writes one destination element per clock. For each write it drives a read address and takes the source element back on `rd_data` in the same cycle, through a combinational read of the store. When the last element has been written, `done` pulses for one cycle. A configuration that cannot be carried out raises `err` for one cycle, and nothing is written.

Top module: `swz_engine`

## Requirements
- R1: For subvector i (0 to vl-1), destination lane j receives the source element at index i*src_len + sel[j]. Selector j is held in bits [2j+1:2j] of `sel`.
- R2: Element index k of a region is at byte address base + k*bytes, stored little-endian. Destination element j of subvector i is written at index i*dst_len + j, with `wr_size` equal to `ew`, and every write in one operation goes to a different address.
- R3: `src_len` and `dst_len` are independent. With 3 in, 4 out and selectors [0,0,2,1], lane 0 appears twice in each output subvector.
- R4: With `dst_len` = 1, one chosen lane of every source subvector is packed into a dense vector.
- R5: `ew` selects the element width: 0=8, 1=16, 2=32, 3=64 bits. Bytes of `wr_data` above the element width are zero.
- R6: After an accepted `start`, exactly vl*dst_len writes follow, one per cycle and with no gaps. The first is in the cycle after the start edge.
- R7: `done` is high for exactly one cycle, in the cycle after the last write. Writes never stop without it.
- R8: When `vl` is 0, nothing is written, and `done` pulses in the cycle after the start edge.
- R9: When `src_len` or `dst_len` is outside 1..4, or any used selector (j < dst_len) is not less than `src_len`, `err` pulses in the cycle after the start edge. In that case there are no writes and no `done`.
- R10: A `start` that arrives while an operation is in progress is ignored, and the running operation finishes unchanged.
- R11: While reset is held, `wr_en`, `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation request |
| vl | input | VL_W | Number of subvectors |
| src_len | input | LW | Source subvector length |
| dst_len | input | LW | Destination subvector length |
| ew | input | 2 | Element width code |
| sel | input | LANES*SELW | Packed lane selectors, lane 0 in the low bits |
| src_base | input | AW | Source region byte address |
| dst_base | input | AW | Destination region byte address |
| rd_addr | output | AW | Byte address of the element being read |
| rd_data | input | 64 | Little-endian data at `rd_addr` |
| wr_en | output | 1 | Element write strobe |
| wr_addr | output | AW | Byte address of the element being written |
| wr_data | output | 64 | Element data, zero above the element width |
| wr_size | output | 2 | Width code of the write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Configuration error pulse |

## Verification
The assertions check the temporal rules on every cycle. `done` and `err` are single-cycle pulses that never coincide with a write. A write burst only begins after a start and only ends with `done`. The write size stays fixed through a burst, and consecutive writes target different addresses. Which source element lands at which destination address can only be shown by the bench's scenarios. The same holds for the exact write count and cycle of `done`, the untouched store after a rejected or empty operation, and the immunity of a running operation to a second start. For these, the bench compares a reference store, built from the rules, byte for byte against the modelled store.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_BAD  = 2'd3
  } swz_state_e;

  // byte count of one element for a width code
  function automatic logic [3:0] lane_bytes(input logic [1:0] ew);
    return 4'd1 << ew;
  endfunction

  // byte address of element idx in a region starting at base
  function automatic logic [31:0] elem_addr(input logic [31:0] base,
                                            input logic [31:0] idx,
                                            input logic [1:0]  ew);
    return base + (idx << ew);
  endfunction

  // keeps only the bytes that belong to one element
  function automatic logic [63:0] width_mask(input logic [1:0] ew);
    case (ew)
      2'd0:    return 64'h0000_0000_0000_00ff;
      2'd1:    return 64'h0000_0000_0000_ffff;
      2'd2:    return 64'h0000_0000_ffff_ffff;
      default: return 64'hffff_ffff_ffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/swz_cfg_check.sv
module swz_cfg_check #(
  parameter int LANES = 4,
  parameter int SELW  = 2,
  parameter int LW    = 3
) (
  input  logic [LW-1:0]         src_len,
  input  logic [LW-1:0]         dst_len,
  input  logic [LANES*SELW-1:0] sel,
  output logic                  cfg_ok
);
  logic [LANES-1:0] lane_ok;
  logic             src_len_ok;
  logic             dst_len_ok;

  assign src_len_ok = (src_len != '0) && (src_len <= LW'(LANES));
  assign dst_len_ok = (dst_len != '0) && (dst_len <= LW'(LANES));

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [SELW-1:0] pick;
    assign pick       = sel[j*SELW +: SELW];
    assign lane_ok[j] = (LW'(j) >= dst_len) || (LW'(pick) < src_len);
  end

  assign cfg_ok = src_len_ok && dst_len_ok && (&lane_ok);
endmodule

// File: rtl/swz_seq.sv
module swz_seq
  import swz_pkg::*;
#(
  parameter int VL_W = 8,
  parameter int LW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cfg_ok,
  input  logic [VL_W-1:0] vl,
  input  logic [LW-1:0]   dst_len,
  output logic            accept,
  output logic [VL_W-1:0] sub_idx,
  output logic [LW-1:0]   lane_idx,
  output logic            wr_fire,
  output logic            fin,
  output logic            bad,
  output logic            busy
);
  swz_state_e      state_q;
  logic [VL_W-1:0] vl_q;
  logic [LW-1:0]   dlen_q;
  logic            last_lane;
  logic            last_sub;

  assign accept    = start && (state_q == ST_IDLE);
  assign last_lane = (lane_idx + LW'(1)) == dlen_q;
  assign last_sub  = sub_idx == (vl_q - VL_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sub_idx  <= '0;
      lane_idx <= '0;
      vl_q     <= '0;
      dlen_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          sub_idx  <= '0;
          lane_idx <= '0;
          vl_q     <= vl;
          dlen_q   <= dst_len;
          if (!cfg_ok)          state_q <= ST_BAD;
          else if (vl == '0)    state_q <= ST_FIN;
          else                  state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (last_lane) begin
            lane_idx <= '0;
            if (last_sub) state_q <= ST_FIN;
            else          sub_idx <= sub_idx + VL_W'(1);
          end else begin
            lane_idx <= lane_idx + LW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_fire = state_q == ST_RUN;
  assign fin     = state_q == ST_FIN;
  assign bad     = state_q == ST_BAD;
  assign busy    = state_q != ST_IDLE;
endmodule

// File: rtl/swz_addr.sv
module swz_addr
  import swz_pkg::*;
#(
  parameter int AW    = 10,
  parameter int VL_W  = 8,
  parameter int LANES = 4,
  parameter int SELW  = 2,
  parameter int LW    = 3
) (
  input  logic [AW-1:0]         src_base,
  input  logic [AW-1:0]         dst_base,
  input  logic [LW-1:0]         src_len,
  input  logic [LW-1:0]         dst_len,
  input  logic [1:0]            ew,
  input  logic [LANES*SELW-1:0] sel,
  input  logic [VL_W-1:0]       sub_idx,
  input  logic [LW-1:0]         lane_idx,
  output logic [AW-1:0]         rd_addr,
  output logic [AW-1:0]         wr_addr
);
  logic [SELW-1:0] pick;
  logic [31:0]     src_idx;
  logic [31:0]     dst_idx;
  logic [31:0]     rd_full;
  logic [31:0]     wr_full;

  always_comb begin
    pick = '0;
    for (int k = 0; k < LANES; k++)
      if (LW'(k) == lane_idx) pick = sel[k*SELW +: SELW];
  end

  assign src_idx = 32'(sub_idx) * 32'(src_len) + 32'(pick);
  assign dst_idx = 32'(sub_idx) * 32'(dst_len) + 32'(lane_idx);
  assign rd_full = elem_addr(32'(src_base), src_idx, ew);
  assign wr_full = elem_addr(32'(dst_base), dst_idx, ew);
  assign rd_addr = rd_full[AW-1:0];
  assign wr_addr = wr_full[AW-1:0];
endmodule

// File: rtl/swz_engine.sv
module swz_engine
  import swz_pkg::*;
#(
  parameter int AW    = 10,
  parameter int VL_W  = 8,
  parameter int LANES = 4,
  parameter int SELW  = $clog2(LANES),
  parameter int LW    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VL_W-1:0]       vl,
  input  logic [LW-1:0]         src_len,
  input  logic [LW-1:0]         dst_len,
  input  logic [1:0]            ew,
  input  logic [LANES*SELW-1:0] sel,
  input  logic [AW-1:0]         src_base,
  input  logic [AW-1:0]         dst_base,
  output logic [AW-1:0]         rd_addr,
  input  logic [63:0]           rd_data,
  output logic                  wr_en,
  output logic [AW-1:0]         wr_addr,
  output logic [63:0]           wr_data,
  output logic [1:0]            wr_size,
  output logic                  busy,
  output logic                  done,
  output logic                  err
);
  logic                  cfg_ok;
  logic                  accept;
  logic [VL_W-1:0]       sub_idx;
  logic [LW-1:0]         lane_idx;
  logic [AW-1:0]         sbase_q, dbase_q;
  logic [LW-1:0]         slen_q, dlen_q;
  logic [1:0]            ew_q;
  logic [LANES*SELW-1:0] sel_q;

  swz_cfg_check #(.LANES(LANES), .SELW(SELW), .LW(LW)) u_cfg (
    .src_len (src_len),
    .dst_len (dst_len),
    .sel     (sel),
    .cfg_ok  (cfg_ok)
  );

  swz_seq #(.VL_W(VL_W), .LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cfg_ok   (cfg_ok),
    .vl       (vl),
    .dst_len  (dst_len),
    .accept   (accept),
    .sub_idx  (sub_idx),
    .lane_idx (lane_idx),
    .wr_fire  (wr_en),
    .fin      (done),
    .bad      (err),
    .busy     (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbase_q <= '0;
      dbase_q <= '0;
      slen_q  <= '0;
      dlen_q  <= '0;
      ew_q    <= '0;
      sel_q   <= '0;
    end else if (accept) begin
      sbase_q <= src_base;
      dbase_q <= dst_base;
      slen_q  <= src_len;
      dlen_q  <= dst_len;
      ew_q    <= ew;
      sel_q   <= sel;
    end
  end

  swz_addr #(.AW(AW), .VL_W(VL_W), .LANES(LANES), .SELW(SELW), .LW(LW)) u_addr (
    .src_base (sbase_q),
    .dst_base (dbase_q),
    .src_len  (slen_q),
    .dst_len  (dlen_q),
    .ew       (ew_q),
    .sel      (sel_q),
    .sub_idx  (sub_idx),
    .lane_idx (lane_idx),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr)
  );

  assign wr_data = rd_data & width_mask(ew_q);
  assign wr_size = ew_q;
endmodule

// File: rtl/swz_engine_chk.sv
module swz_engine_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_size,
  input logic          done,
  input logic          err
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_burst_ends_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !wr_en) |-> done);

  assert_err_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!wr_en && !done));

  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (!err && !wr_en));

  assert_burst_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !$past(wr_en)) |-> $past(start));

  assert_size_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> $stable(wr_size));

  assert_addr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr != $past(wr_addr)));
endmodule

bind swz_engine swz_engine_chk #(.AW(AW)) u_swz_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_size (wr_size),
  .done    (done),
  .err     (err)
);

// File: tb/test_swz_engine.sv
`timescale 1ns/1ps
module test_swz_engine;
  localparam int AW = 10;
  localparam int MEM = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    vl = '0;
  logic [2:0]    src_len = '0, dst_len = '0;
  logic [1:0]    ew = '0;
  logic [7:0]    sel = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [63:0]   rd_data, wr_data;
  logic          wr_en, busy, done, err;
  logic [1:0]    wr_size;

  logic [7:0] mem [MEM];
  logic [7:0] ref_mem [MEM];
  int n_chk = 0, n_bad = 0, cyc_all = 0;

  always #2.5 clk = ~clk;

  swz_engine i_swz_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_len(src_len),
    .dst_len(dst_len), .ew(ew), .sel(sel), .src_base(src_base),
    .dst_base(dst_base), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_size(wr_size), .busy(busy),
    .done(done), .err(err)
  );

  always_comb
    for (int b = 0; b < 8; b++) rd_data[8*b +: 8] = mem[(int'(rd_addr) + b) % MEM];

  always @(posedge clk)
    if (wr_en)
      for (int b = 0; b < (1 << wr_size); b++)
        mem[(int'(wr_addr) + b) % MEM] <= wr_data[8*b +: 8];

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] pk(input int a, input int b, input int c, input int d);
    return {2'(d), 2'(c), 2'(b), 2'(a)};
  endfunction

  // one operation: fills the store, builds the reference, runs, compares
  task automatic run_op(input string req, input int n_vl, input int s, input int d,
                        input int e, input logic [7:0] sl, input int sb, input int db,
                        input int seed, input bit inject);
    int  nbytes = 1 << e;
    bit  ok_cfg;
    int  nw = 0, first_w = -1, last_w = -1, done_c = -1, err_c = -1, n_done = 0;
    int  lim;
    for (int k = 0; k < MEM; k++) begin
      mem[k] = 8'(k * 13 + seed);
      ref_mem[k] = 8'(k * 13 + seed);
    end
    ok_cfg = (s >= 1 && s <= 4 && d >= 1 && d <= 4);
    for (int j = 0; j < 4; j++)
      if (j < d && int'(sl[2*j +: 2]) >= s) ok_cfg = 0;
    if (ok_cfg)
      for (int i = 0; i < n_vl; i++)
        for (int j = 0; j < d; j++) begin
          int si = i * s + int'(sl[2*j +: 2]);
          int di = i * d + j;
          for (int b = 0; b < nbytes; b++)
            ref_mem[db + di * nbytes + b] = mem[sb + si * nbytes + b];
        end
    lim = n_vl * d + 6;
    @(negedge clk);
    vl = 8'(n_vl); src_len = 3'(s); dst_len = 3'(d); ew = 2'(e); sel = sl;
    src_base = AW'(sb); dst_base = AW'(db); start = 1'b1;
    for (int c = 1; c <= lim; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (inject && c == 2) begin
        // R10: a second request with other settings while running
        start = 1'b1; vl = 8'd1; src_len = 3'd1; dst_len = 3'd1; ew = 2'd3;
        sel = 8'h0; src_base = '0; dst_base = '0;
      end
      if (wr_en) begin
        nw++;
        if (first_w < 0) first_w = c;
        last_w = c;
      end
      if (done) begin n_done++; if (done_c < 0) done_c = c; end
      if (err && err_c < 0) err_c = c;
    end
    start = 1'b0;
    if (!ok_cfg) begin
      check(err_c == 1, "R9", {req, " err cycle"}, err_c, 1);
      check(nw == 0 && n_done == 0, "R9", {req, " writes+done"}, nw + n_done, 0);
    end else if (n_vl == 0) begin
      check(nw == 0, "R8", {req, " writes"}, nw, 0);
      check(done_c == 1, "R8", {req, " done cycle"}, done_c, 1);
    end else begin
      check(nw == n_vl * d && first_w == 1 && last_w == nw, "R6",
            {req, " write count"}, nw, n_vl * d);
      check(done_c == n_vl * d + 1 && n_done == 1, "R7",
            {req, " done cycle"}, done_c, n_vl * d + 1);
    end
    begin
      int bad_at = -1;
      for (int k = 0; k < MEM; k++)
        if (bad_at < 0 && mem[k] !== ref_mem[k]) bad_at = k;
      if (bad_at < 0) check(1, req, "store", 0, 0);
      else check(0, req, $sformatf("store byte %0d", bad_at),
                 mem[bad_at], ref_mem[bad_at]);
    end
  endtask

  task automatic t_reset;
    // R11: outputs quiet while reset is held
    #1;
    check(!wr_en && !done && !err && !busy, "R11", "quiet during reset",
          {wr_en, done, err, busy}, 0);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R3 R1: 3 in, 4 out, duplicated lane 0
    run_op("R3", 5, 3, 4, 0, pk(0, 0, 2, 1), 16, 256, 1, 0);
    // R1 R2: reversal at 16-bit width, many subvectors
    run_op("R1", 40, 2, 2, 1, pk(1, 0, 0, 0), 0, 400, 2, 0);
    // R4: pull lane 2 of 4 at 32-bit width
    run_op("R4", 5, 4, 1, 2, pk(2, 0, 0, 0), 32, 512, 3, 0);
    // R5: 64-bit elements, full permutation
    run_op("R5", 5, 4, 4, 3, pk(3, 1, 0, 2), 0, 512, 4, 0);
    // R2: 8-bit identity copy, odd bases
    run_op("R2", 7, 1, 1, 0, pk(0, 0, 0, 0), 3, 701, 5, 0);
    // R8: empty operation
    run_op("R8", 0, 3, 4, 0, pk(0, 0, 2, 1), 0, 256, 6, 0);
    // R9: selector out of range, zero length, over-long destination
    run_op("R9", 4, 2, 3, 0, pk(0, 1, 2, 0), 0, 256, 7, 0);
    run_op("R9", 4, 0, 2, 0, pk(0, 0, 0, 0), 0, 256, 8, 0);
    run_op("R9", 4, 2, 5, 0, pk(0, 0, 0, 0), 0, 256, 9, 0);
    // R9 boundary: unused lane selector above range is accepted
    run_op("R9", 3, 2, 2, 0, pk(1, 0, 3, 3), 0, 256, 10, 0);
    // R10: a second start mid-run is ignored
    run_op("R10", 6, 3, 3, 1, pk(2, 1, 0, 0), 8, 600, 11, 1);
    @(negedge clk);
    check(!busy, "R10", "idle after run", busy, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule